// File: doc/BRIEF.md
# Predictive Fill Trigger

This block sits beside a small line cache and decides, access by access, whether the next line should be fetched ahead of demand. Each access names the line it touches and the byte offset of the access within an 8-byte line. A programmable 8-bit mask selects which offsets may start a fetch. Offset 7 corresponds to mask bit 0 and offset 0 to mask bit 7. This lets software choose how early in a line the prefetch begins, from the first byte touched down to only the last bytes.

By default only accesses flagged as streaming may start a fetch. A force input makes every access eligible. The block issues at most one request per line. It does not queue a request while the fill engine is occupied; that request is dropped. The output is a single-cycle pulse registered one clock after the access that caused it. The fetch itself and the choice of victim line are handled elsewhere.

Top module: `pfill_trig`

## Requirements
- R1: While rst_ni is low, fill_trig_o is 0. The first access after reset counts as an access to a new line, whatever its line address.
- R2: fill_trig_o is high for exactly the one cycle after the clock edge at which a triggering access is sampled. It stays low in every cycle that follows an edge with acc_valid_i low.
- R3: An access at byte offset k (acc_off_i = k, 0 to 7) can trigger only if mask_i bit (7 - k) is 1. For example, mask 0x3F admits offsets 2 to 7, mask 0x03 admits offsets 6 and 7, and mask 0xFF admits every offset.
- R4: With mask_i equal to 0x00, no access ever triggers.
- R5: An access is eligible only if stream_i or force_all_i is 1. With both inputs 0, the access never triggers.
- R6: After a trigger, further accesses to the same acc_line_i value do not trigger again. This holds until an access to a different line value is sampled.
- R7: An access sampled while busy_i is 1 does not trigger, and it causes no later trigger. A later access to the same line that meets all conditions may still trigger.
- R8: Any sampled access to a line value different from the last one re-arms the block, including an access that does not trigger. An eligible access to the new line may then trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe, one access per cycle |
| acc_line_i | input | LINE_W | Line address of the access |
| acc_off_i | input | OFF_W | Byte offset of the access within its line |
| stream_i | input | 1 | Access belongs to a streaming sequence |
| force_all_i | input | 1 | Make every access eligible, not only streaming ones |
| mask_i | input | 2**OFF_W | Offset mask; bit i enables offset (2**OFF_W - 1 - i) |
| busy_i | input | 1 | Fill engine cannot accept a request this cycle |
| fill_trig_o | output | 1 | One-cycle request to fetch the next line |

## Verification
The assertions compare each pulse with the inputs sampled one cycle earlier. They therefore assume that the mask, offset, mode bits and busy are valid in every cycle that the strobe is high. The no-repeat property assumes that line addresses arrive directly on acc_line_i, with no gaps that hide a line change. Random stimulus draws line addresses from a set of four values, so same-line runs and line switches both occur often. Every input is driven to a defined value on every cycle, and inputs change only between clock edges.

// File: rtl/pfill_pkg.sv
package pfill_pkg;
  localparam int unsigned LINE_W_DEF = 16;
  localparam int unsigned OFF_W_DEF  = 3;

  function automatic logic acc_eligible(input logic stream, input logic force_all);
    return stream | force_all;
  endfunction
endpackage

// File: rtl/pfill_off_sel.sv
module pfill_off_sel #(
  parameter int unsigned OFF_W      = 3,
  parameter int unsigned LINE_BYTES = 1 << OFF_W
) (
  input  logic [OFF_W-1:0]      off_i,
  input  logic [LINE_BYTES-1:0] mask_i,
  output logic                  hit_o
);
  logic [LINE_BYTES-1:0] pos_en;

  // mask MSB maps to offset 0
  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_pos
    localparam int unsigned MBIT = LINE_BYTES - 1 - k;
    assign pos_en[k] = (off_i == OFF_W'(k)) & mask_i[MBIT];
  end

  assign hit_o = |pos_en;
endmodule

// File: rtl/pfill_line_trk.sv
module pfill_line_trk #(
  parameter int unsigned LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              fire_i,
  output logic              blocked_o
);
  logic              have_q;
  logic              fired_q;
  logic [LINE_W-1:0] line_q;
  logic              same_line;

  assign same_line = have_q && (line_i == line_q);
  assign blocked_o = same_line && fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      fired_q <= 1'b0;
      line_q  <= '0;
    end else if (acc_i) begin
      have_q  <= 1'b1;
      line_q  <= line_i;
      fired_q <= same_line ? (fired_q | fire_i) : fire_i;
    end
  end
endmodule

// File: rtl/pfill_trig.sv
module pfill_trig
  import pfill_pkg::*;
#(
  parameter int unsigned LINE_W     = LINE_W_DEF,
  parameter int unsigned OFF_W      = OFF_W_DEF,
  localparam int unsigned LINE_BYTES = 1 << OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acc_valid_i,
  input  logic [LINE_W-1:0]     acc_line_i,
  input  logic [OFF_W-1:0]      acc_off_i,
  input  logic                  stream_i,
  input  logic                  force_all_i,
  input  logic [LINE_BYTES-1:0] mask_i,
  input  logic                  busy_i,
  output logic                  fill_trig_o
);
  logic off_hit;
  logic line_blocked;
  logic want;
  logic fire;
  logic trig_q;

  pfill_off_sel #(.OFF_W(OFF_W), .LINE_BYTES(LINE_BYTES)) u_off_sel (
    .off_i  (acc_off_i),
    .mask_i (mask_i),
    .hit_o  (off_hit)
  );

  pfill_line_trk #(.LINE_W(LINE_W)) u_line_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc_valid_i),
    .line_i    (acc_line_i),
    .fire_i    (fire),
    .blocked_o (line_blocked)
  );

  assign want = acc_valid_i && acc_eligible(stream_i, force_all_i) && off_hit;
  // busy drops the request, nothing is held pending
  assign fire = want && !line_blocked && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= fire;
  end

  assign fill_trig_o = trig_q;
endmodule

// File: rtl/pfill_trig_chk.sv
module pfill_trig_chk #(
  parameter int unsigned LINE_W     = 16,
  parameter int unsigned OFF_W      = 3,
  parameter int unsigned LINE_BYTES = 1 << OFF_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  acc_valid_i,
  input logic [LINE_W-1:0]     acc_line_i,
  input logic [OFF_W-1:0]      acc_off_i,
  input logic                  stream_i,
  input logic                  force_all_i,
  input logic [LINE_BYTES-1:0] mask_i,
  input logic                  busy_i,
  input logic                  fill_trig_o
);
  logic [OFF_W-1:0] rev_off;
  logic             sel_bit;
  logic             seen_q;

  assign rev_off = ~acc_off_i;
  assign sel_bit = mask_i[rev_off];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_trig_needs_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_trig_o |-> $past(acc_valid_i));

  assert_trig_mask_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_trig_o |-> $past(sel_bit));

  assert_zero_mask_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_trig_o |-> ($past(mask_i) != '0));

  assert_trig_eligible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_trig_o |-> $past(stream_i || force_all_i));

  assert_back_to_back_new_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_trig_o && $past(fill_trig_o) && seen_q) |-> ($past(acc_line_i, 1) != $past(acc_line_i, 2)));

  assert_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_trig_o |-> !$past(busy_i));
endmodule

bind pfill_trig pfill_trig_chk #(.LINE_W(LINE_W), .OFF_W(OFF_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_line_i  (acc_line_i),
  .acc_off_i   (acc_off_i),
  .stream_i    (stream_i),
  .force_all_i (force_all_i),
  .mask_i      (mask_i),
  .busy_i      (busy_i),
  .fill_trig_o (fill_trig_o)
);

// File: tb/pfill_trig_tb_top.sv
`timescale 1ns/1ps
module pfill_trig_tb_top;
  localparam int unsigned LINE_W = 16;
  localparam int unsigned OFF_W  = 3;
  localparam int unsigned NB     = 1 << OFF_W;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              acc_valid_i;
  logic [LINE_W-1:0] acc_line_i;
  logic [OFF_W-1:0]  acc_off_i;
  logic              stream_i;
  logic              force_all_i;
  logic [NB-1:0]     mask_i;
  logic              busy_i;
  logic              fill_trig_o;

  int total = 0;
  int bad   = 0;

  // bench model state
  logic              m_have;
  logic              m_fired;
  logic [LINE_W-1:0] m_line;

  always #10 clk_i = ~clk_i;

  pfill_trig #(.LINE_W(LINE_W), .OFF_W(OFF_W)) dut_i (
    .clk_i, .rst_ni, .acc_valid_i, .acc_line_i, .acc_off_i,
    .stream_i, .force_all_i, .mask_i, .busy_i, .fill_trig_o
  );

  task automatic check(input logic exp, input string tag);
    total++;
    if (fill_trig_o !== exp) begin
      bad++;
      $display("FAIL %s: fill_trig_o=%b expected=%b at %0t", tag, fill_trig_o, exp, $time);
    end
  endtask

  // called at a falling edge; drives one access, checks the pulse one edge later
  task automatic cyc(input logic v, input logic [LINE_W-1:0] ln, input logic [OFF_W-1:0] off,
                     input logic st, input logic fa, input logic [NB-1:0] mk, input logic bz);
    logic  new_line, elig, hit, blocked, exp;
    string tag;
    acc_valid_i = v; acc_line_i = ln; acc_off_i = off;
    stream_i = st; force_all_i = fa; mask_i = mk; busy_i = bz;
    new_line = !m_have || (ln != m_line);
    elig     = st || fa;
    hit      = mk[NB-1-int'(off)];
    blocked  = !new_line && m_fired;
    exp      = v && elig && hit && !blocked && !bz;
    if (!v)                              tag = "R2";
    else if (elig && hit && bz)          tag = "R7";
    else if (elig && hit && blocked)     tag = "R6";
    else if (!elig)                      tag = "R5";
    else if (mk == '0)                   tag = "R4";
    else if (new_line && m_have && exp)  tag = "R8";
    else                                 tag = "R3";
    if (v) begin
      if (new_line) begin m_have = 1'b1; m_line = ln; m_fired = exp; end
      else if (exp) m_fired = 1'b1;
    end
    @(negedge clk_i);
    check(exp, tag);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_have = 1'b0; m_fired = 1'b0; m_line = '0;
    rst_ni = 1'b0;
    acc_valid_i = 1'b1; acc_line_i = '0; acc_off_i = 3'd7;
    stream_i = 1'b1; force_all_i = 1'b0; mask_i = 8'hFF; busy_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(1'b0, "R1");
    end
    rst_ni = 1'b1;
    acc_valid_i = 1'b0;
    @(negedge clk_i);
    check(1'b0, "R1");

    // R1: first access after reset, line 0, is a new line
    cyc(1, 16'h0000, 3'd7, 1, 0, 8'h01, 0);
    cyc(0, 16'h0000, 3'd7, 1, 0, 8'h01, 0); // R2 single-cycle pulse
    // R3: 0x3F offsets, one fresh line each
    for (int k = 0; k < 8; k++) cyc(1, 16'h0100 + 16'(k), 3'(k), 1, 0, 8'h3F, 0);
    // R3: 0x03
    for (int k = 0; k < 8; k++) cyc(1, 16'h0200 + 16'(k), 3'(k), 1, 0, 8'h03, 0);
    // R4: zero mask
    for (int k = 0; k < 8; k++) cyc(1, 16'h0300 + 16'(k), 3'(k), 1, 1, 8'h00, 0);
    // R5: not streaming, then forced
    cyc(1, 16'h0400, 3'd0, 0, 0, 8'hFF, 0);
    cyc(1, 16'h0401, 3'd0, 0, 1, 8'hFF, 0);
    // R6: repeated same line
    cyc(1, 16'h0500, 3'd0, 1, 0, 8'hFF, 0);
    cyc(1, 16'h0500, 3'd3, 1, 0, 8'hFF, 0);
    cyc(1, 16'h0500, 3'd7, 1, 0, 8'hFF, 0);
    // R8: ineligible access to another line re-arms, then back
    cyc(1, 16'h0501, 3'd0, 0, 0, 8'hFF, 0);
    cyc(1, 16'h0500, 3'd1, 1, 0, 8'hFF, 0);
    // R7: busy drops, no retry; later access same line fires
    cyc(1, 16'h0600, 3'd6, 1, 0, 8'h03, 1);
    cyc(0, 16'h0600, 3'd6, 1, 0, 8'h03, 0);
    cyc(1, 16'h0600, 3'd7, 1, 0, 8'h03, 0);

    // random mix
    void'($urandom(32'd4711));
    for (int n = 0; n < 4000; n++) begin
      logic [NB-1:0] mk;
      int sel;
      sel = $urandom_range(0, 9);
      mk  = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : NB'($urandom);
      cyc($urandom_range(0, 3) != 0, 16'($urandom_range(0, 3)), 3'($urandom),
          $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, mk,
          $urandom_range(0, 3) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule